// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block judges one data block of up to 512 bytes after a read. It compares the three check bytes that were stored with the block against three check bytes computed over the data as it was read back. From the bitwise difference, called the syndrome, it decides one of four outcomes. The data may be clean. It may hold a single flipped data bit, which can be repaired. The stored check bytes themselves may be damaged. Or the block may be beyond repair. For a repairable data bit it reports where the bit is, as a 9-bit byte position and a 3-bit bit position.

A caller loads both check-byte sets, raises `start` for one cycle, and reads the verdict on the cycle that `done` pulses. The verdict stays on the outputs until the next `start`. An optional input treats a stored check field of all ones as a page that was written without protection. A separate byte port repairs the data in place. The caller presents each data byte together with its position, and the port returns that byte with the faulty bit inverted when the position matches a repairable error. Any other byte passes through unchanged.

Stored and computed check bytes are packed with byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. On small-page devices a block is 512 bytes and its check bytes sit in spare bytes 0 to 2. On large-page devices a block is 256 bytes, also with three check bytes.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: After reset, `done`, all four status outputs, `err_byte`, `err_bit` are 0, and `fix_out` equals `fix_in`.
- R2: `done` is high for exactly the cycle after each cycle in which `start` is high. Status and positions change only on that edge and are held otherwise.
- R3: Syndrome bytes s0, s1 and s2 are each the XOR of stored byte k and computed byte k. A syndrome of all zeros gives `st_clean`.
- R4: With `ignore_unset` high and a stored field of 0xFFFFFF, the result is `st_clean` whatever the computed bytes are. With `ignore_unset` low, the same inputs are classified normally.
- R5: A nonzero syndrome is a repairable data error (`st_data_fix`) when, for every syndrome byte s, ((s ^ (s>>1)) & 0x55) == 0x55. That is, within each bit pair (2k+1, 2k), the two bits differ.
- R6: For a data error, `err_bit` bits 0, 1 and 2 are s2 bits 3, 5 and 7.
- R7: For a data error, `err_byte` bits 0 to 3 are s0 bits 1, 3, 5 and 7. Bits 4 to 7 are s1 bits 1, 3, 5 and 7. Bit 8 is s2 bit 1.
- R8: A syndrome {s2,s1,s0} with exactly one bit set gives `st_ecc_fix`. It reports both positions as 0 and leaves data bytes unchanged.
- R9: Every other nonzero syndrome gives `st_uncorr`, with both positions 0.
- R10: While `st_data_fix` is high and `fix_index` equals `err_byte`, `fix_out` is `fix_in` with bit `err_bit` inverted. In every other case `fix_out` equals `fix_in`.
- R11: After the first `done`, exactly one of the four status outputs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to classify the present check bytes |
| ignore_unset | input | 1 | Treat an all-ones stored field as unprotected |
| stored_ecc | input | 24 | Check bytes read from the spare area |
| calc_ecc | input | 24 | Check bytes computed over the data read back |
| fix_index | input | 9 | Position of the byte presented for repair |
| fix_in | input | 8 | Data byte presented for repair |
| done | output | 1 | Verdict valid pulse |
| st_clean | output | 1 | No error |
| st_data_fix | output | 1 | Single data bit error, repairable |
| st_ecc_fix | output | 1 | Error confined to the stored check bytes |
| st_uncorr | output | 1 | Uncorrectable |
| err_byte | output | 9 | Byte position of the faulty data bit |
| err_bit | output | 3 | Bit position within that byte |
| fix_out | output | 8 | Repaired data byte |

## Verification
The hardest outcome to reach from the ports is a repairable data error at a chosen position. It needs all twelve bit pairs of the syndrome to differ at once, with the position bits spread across all three bytes. Random check bytes almost never produce this. The bench therefore builds the syndrome from a target byte and bit position: each position bit becomes the pair pattern 10 or 01. It then XORs that syndrome into arbitrary stored bytes to get the computed bytes. Extreme positions such as 0, 511 and alternating patterns exercise every field bit. The all-ones stored field is run with the ignore option both on and off, to show that the option alone decides that verdict.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_BYTES  = 3;
  localparam int unsigned SYN_W    = BYTE_W * N_BYTES;
  localparam int unsigned PAIRS    = BYTE_W / 2;
  localparam int unsigned POS_W    = 2 * PAIRS + 1;
  localparam int unsigned BITPOS_W = 3;
  localparam int unsigned N_STATUS = 4;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_DATA   = 2'd1,
    CLS_ECC    = 2'd2,
    CLS_UNCORR = 2'd3
  } ecc_cls_e;

  // every bit pair (2k+1, 2k) of one syndrome byte holds differing bits
  function automatic logic pairs_differ(input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] mask;
    mask = '0;
    for (int k = 0; k < BYTE_W; k += 2) mask[k] = 1'b1;
    return ((s ^ (s >> 1)) & mask) == mask;
  endfunction

  // one-hot status vector: bit0 clean, bit1 data, bit2 ecc, bit3 uncorr
  function automatic logic [N_STATUS-1:0] cls_onehot(input ecc_cls_e c);
    logic [N_STATUS-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_syn_pkg::*;
(
  input  logic [SYN_W-1:0] stored_ecc,
  input  logic [SYN_W-1:0] syn,
  input  logic             ignore_unset,
  output logic             syn_zero,
  output logic             unset_hit,
  output logic             pairs_ok,
  output logic             syn_single,
  output ecc_cls_e         cls
);
  logic [N_BYTES-1:0] byte_ok;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_pair
    assign byte_ok[b] = pairs_differ(syn[b*BYTE_W +: BYTE_W]);
  end

  assign syn_zero   = (syn == '0);
  assign unset_hit  = ignore_unset && (&stored_ecc);
  assign pairs_ok   = &byte_ok;
  assign syn_single = ($countones(syn) == 1);

  always_comb begin
    if (syn_zero || unset_hit) cls = CLS_CLEAN;
    else if (pairs_ok)         cls = CLS_DATA;
    else if (syn_single)       cls = CLS_ECC;
    else                       cls = CLS_UNCORR;
  end
endmodule

// File: rtl/ecc_syn_locate.sv
module ecc_syn_locate
  import ecc_syn_pkg::*;
(
  input  logic [SYN_W-1:0]    syn,
  output logic [POS_W-1:0]    byte_pos,
  output logic [BITPOS_W-1:0] bit_pos
);
  logic [BYTE_W-1:0] s0, s1, s2;
  assign s0 = syn[0*BYTE_W +: BYTE_W];
  assign s1 = syn[1*BYTE_W +: BYTE_W];
  assign s2 = syn[2*BYTE_W +: BYTE_W];

  // odd bit of each pair carries one position bit
  for (genvar k = 0; k < PAIRS; k++) begin : g_byte
    assign byte_pos[k]         = s0[2*k+1];
    assign byte_pos[PAIRS + k] = s1[2*k+1];
  end
  assign byte_pos[POS_W-1] = s2[1];

  for (genvar j = 0; j < BITPOS_W; j++) begin : g_bit
    assign bit_pos[j] = s2[2*j+3];
  end
endmodule

// File: rtl/ecc_syn_patch.sv
module ecc_syn_patch
  import ecc_syn_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fix_en,
  input  logic [POS_W-1:0]    err_byte,
  input  logic [BITPOS_W-1:0] err_bit,
  input  logic [POS_W-1:0]    fix_index,
  input  logic [BYTE_W-1:0]   fix_in,
  output logic [BYTE_W-1:0]   fix_out
);
  logic              hit;
  logic [BYTE_W-1:0] flip;

  assign hit     = fix_en && (fix_index == err_byte);
  assign flip    = hit ? (BYTE_W'(1) << err_bit) : '0;
  assign fix_out = fix_in ^ flip;

  p_pass_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_en |-> (fix_out == fix_in));
  p_single_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(fix_out ^ fix_in) == 1));
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_syn_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                ignore_unset,
  input  logic [SYN_W-1:0]    stored_ecc,
  input  logic [SYN_W-1:0]    calc_ecc,
  input  logic [POS_W-1:0]    fix_index,
  input  logic [BYTE_W-1:0]   fix_in,
  output logic                done,
  output logic                st_clean,
  output logic                st_data_fix,
  output logic                st_ecc_fix,
  output logic                st_uncorr,
  output logic [POS_W-1:0]    err_byte,
  output logic [BITPOS_W-1:0] err_bit,
  output logic [BYTE_W-1:0]   fix_out
);
  logic [SYN_W-1:0]    syn;
  logic                syn_zero, unset_hit, pairs_ok, syn_single;
  ecc_cls_e            cls_d;
  logic [POS_W-1:0]    loc_byte;
  logic [BITPOS_W-1:0] loc_bit;
  logic [N_STATUS-1:0] status_q;
  logic [POS_W-1:0]    byte_q;
  logic [BITPOS_W-1:0] bit_q;
  logic                done_q;

  assign syn = stored_ecc ^ calc_ecc;

  ecc_syn_classify u_classify (
    .stored_ecc   (stored_ecc),
    .syn          (syn),
    .ignore_unset (ignore_unset),
    .syn_zero     (syn_zero),
    .unset_hit    (unset_hit),
    .pairs_ok     (pairs_ok),
    .syn_single   (syn_single),
    .cls          (cls_d)
  );

  ecc_syn_locate u_locate (
    .syn      (syn),
    .byte_pos (loc_byte),
    .bit_pos  (loc_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      byte_q   <= '0;
      bit_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= start;
      if (start) begin
        status_q <= cls_onehot(cls_d);
        byte_q   <= (cls_d == CLS_DATA) ? loc_byte : '0;
        bit_q    <= (cls_d == CLS_DATA) ? loc_bit  : '0;
      end
    end
  end

  assign done        = done_q;
  assign st_clean    = status_q[CLS_CLEAN];
  assign st_data_fix = status_q[CLS_DATA];
  assign st_ecc_fix  = status_q[CLS_ECC];
  assign st_uncorr   = status_q[CLS_UNCORR];
  assign err_byte    = byte_q;
  assign err_bit     = bit_q;

  ecc_syn_patch u_patch (
    .clk       (clk),
    .rst_n     (rst_n),
    .fix_en    (st_data_fix),
    .err_byte  (byte_q),
    .err_bit   (bit_q),
    .fix_index (fix_index),
    .fix_in    (fix_in),
    .fix_out   (fix_out)
  );

  p_status_onehot0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q));
  p_done_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(status_q) == 1));
  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status_q) && $stable(byte_q) && $stable(bit_q)));
  p_zero_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && syn_zero) |=> st_clean);
  p_unset_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && unset_hit) |=> st_clean);
  p_single_ecc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && syn_single && !unset_hit) |=> (st_ecc_fix && err_byte == '0 && err_bit == '0));
  p_ecc_data_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_ecc_fix |-> (fix_out == fix_in));
endmodule

// File: tb/test_ecc_syndrome_corrector.sv
module test_ecc_syndrome_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ignore_unset = 1'b0;
  logic [23:0] stored_ecc = '0;
  logic [23:0] calc_ecc = '0;
  logic [8:0]  fix_index = '0;
  logic [7:0]  fix_in = '0;
  logic        done, st_clean, st_data_fix, st_ecc_fix, st_uncorr;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;
  logic [7:0]  fix_out;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  ecc_syndrome_corrector i_ecc_syndrome_corrector (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // status as {uncorr, ecc, data, clean}
  function automatic logic [3:0] stat();
    return {st_uncorr, st_ecc_fix, st_data_fix, st_clean};
  endfunction

  // build syndrome: each position bit becomes pair 10 (one) or 01 (zero)
  function automatic logic [23:0] make_syn(input logic [8:0] pos, input logic [2:0] b);
    logic [11:0] f;
    logic [23:0] s;
    f = {b[2], b[1], b[0], pos[8], pos[7:4], pos[3:0]};
    for (int k = 0; k < 12; k++) s[2*k +: 2] = f[k] ? 2'b10 : 2'b01;
    return s;
  endfunction

  task automatic run(input logic [23:0] st, input logic [23:0] syn, input logic ign);
    @(negedge clk);
    stored_ecc = st; calc_ecc = st ^ syn; ignore_unset = ign; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 done pulse", done, 1);
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 status", stat(), 0);
    check("R1 pos", {err_byte, err_bit}, 0);
    fix_in = 8'h5A;
    #1 check("R1 fix_out", fix_out, 8'h5A);
  endtask

  task automatic t_clean();
    run(24'h3C91E4, 24'h0, 1'b0);
    check("R3 clean", stat(), 4'b0001);
    check("R3 pos", {err_byte, err_bit}, 0);
    @(negedge clk);
    check("R2 done drops", done, 0);
    check("R2 hold", stat(), 4'b0001);
  endtask

  task automatic t_data(input logic [8:0] pos, input logic [2:0] b, input logic [23:0] st);
    run(st, make_syn(pos, b), 1'b0);
    check("R5 data class", stat(), 4'b0010);
    check("R11 onehot", $countones(stat()), 1);
    check("R6 bit pos", err_bit, b);
    check("R7 byte pos", err_byte, pos);
  endtask

  task automatic t_patch();
    t_data(9'h1A5, 3'd6, 24'h0F0F0F);
    fix_index = 9'h1A5; fix_in = 8'h00;
    #1 check("R10 flip", fix_out, 8'h40);
    fix_in = 8'hFF;
    #1 check("R10 flip ones", fix_out, 8'hBF);
    fix_index = 9'h1A4;
    #1 check("R10 other byte", fix_out, 8'hFF);
  endtask

  task automatic t_ecc(input logic [4:0] k);
    run(24'hA5A5A5, 24'h1 << k, 1'b0);
    check("R8 ecc class", stat(), 4'b0100);
    check("R8 pos zero", {err_byte, err_bit}, 0);
    fix_index = 9'h0; fix_in = 8'h33;
    #1 check("R8 data kept", fix_out, 8'h33);
  endtask

  task automatic t_bad(input logic [23:0] syn);
    run(24'h123456, syn, 1'b0);
    check("R9 uncorr", stat(), 4'b1000);
    check("R9 pos zero", {err_byte, err_bit}, 0);
    fix_index = 9'h0; fix_in = 8'h81;
    #1 check("R9 data kept", fix_out, 8'h81);
  endtask

  task automatic t_unset();
    run(24'hFFFFFF, 24'hFFFFFF ^ 24'h123456, 1'b1);
    check("R4 ignored", stat(), 4'b0001);
    // syndrome 0xEDCBA9: byte1 pair0 is 11, not single bit
    run(24'hFFFFFF, 24'hFFFFFF ^ 24'h123456, 1'b0);
    check("R4 not ignored", stat(), 4'b1000);
    // ignore option with ordinary stored field has no effect
    run(24'hFFFFFE, 24'h000100, 1'b1);
    check("R4 only all-ones", stat(), 4'b0100);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    #10 rst_n = 1'b1;
    t_clean();
    t_data(9'h000, 3'd0, 24'h000000);
    t_data(9'h1FF, 3'd7, 24'hFFFF00);
    t_data(9'h0AA, 3'd5, 24'h5A5A5A);
    t_data(9'h155, 3'd2, 24'hC3C3C3);
    t_patch();
    t_ecc(5'd0);
    t_ecc(5'd9);
    t_ecc(5'd23);
    t_bad(24'h000003);
    t_bad(24'h800001);
    t_bad(24'hFFFFFF);
    t_unset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule